// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the programming state of one DMA channel: a control/status word, a transfer address, a spare word and an upper address base. Software reaches all four as 32-bit words over a simple request/response port. Writes to the control word have side effects. They can pulse a reset toward the attached peripheral, drive its DMA-enable and direction levels, and arm an interrupt gate.

The peripheral side has an interrupt level input, which the block tracks as a pending bit, and a transfer-done strobe with a byte count. The strobe advances the transfer address by that count. The interrupt output is the pending bit qualified by the interrupt-enable bit, and it follows every change of either bit.

Top module: `dmach_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, words 1 to 3 read 0, and irq_out, dma_en_out, dir_to_mem and per_reset are all low.
- R2: The word index is req_addr[3:2] (0 control, 1 transfer address, 2 spare, 3 address base); higher offset bits are ignored, so offsets 16 bytes apart alias. Words 2 and 3 store and return any written value, and word 3 and word 1 drive xfer_base and xfer_addr.
- R3: req_ready equals req_valid in the same cycle. A write whose req_be is not 4'hF changes nothing, and reads have no side effects.
- R4: On a control write, bits under mask 0xFE000007 keep their old value, and bits 31:29 are always forced to 101 (version 0xA0000000 in the top of the word).
- R5: A control write of exactly 0 stores the drain bit (bit 6), so the word reads 0xA0000040.
- R6: A control write with bit 6 set and bit 7 clear stores bit 6 as 0.
- R7: A control write with bit 7 set drives per_reset high for exactly the one cycle after the write. Bits 7 and 6 are stored as written.
- R8: dma_en_out follows bit 9 and dir_to_mem follows bit 8 of the last control write.
- R9: A rising edge on per_irq_in sets control bit 0 one clock later, and a falling edge clears it. Software cannot write bit 0.
- R10: irq_out is high exactly when control bits 0 and 4 are both set, and it changes in the same cycle the stored enable bit changes.
- R11: A full-word write to word 1 sets control bit 26. Later control writes leave bit 26 unchanged.
- R12: A transfer-done strobe adds xfer_len (16 bits, zero-extended) to the transfer address in one clock, wrapping at 32 bits. A bus write to word 1 in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 write, 0 read |
| req_be | input | 4 | Byte enables; only 4'hF performs a write |
| req_addr | input | ADDR_W | Byte offset into the register window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access acknowledge, same cycle |
| req_rdata | output | 32 | Selected register word |
| per_irq_in | input | 1 | Interrupt level from the peripheral |
| xfer_done | input | 1 | One-cycle strobe: a transfer finished |
| xfer_len | input | LEN_W | Bytes moved by that transfer |
| irq_out | output | 1 | Gated interrupt |
| per_reset | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_out | output | 1 | DMA-enable level to the peripheral |
| dir_to_mem | output | 1 | Transfer direction, 1 = write memory |
| xfer_addr | output | 32 | Current transfer address |
| xfer_base | output | 32 | Upper address base |

## Verification
The bench builds the block with its defaults, ADDR_W = 12 and LEN_W = 16. With 12 address bits, offsets above 15 can be driven, which shows the 16-byte aliasing of the index. A 16-bit length of 0xFFFF can be added twice and then pushed across the 32-bit boundary to exercise the wrap. The one-cycle reset pulse, the gate that reacts in the same cycle, and the precedence between a bus write and an address advance are each sampled in the exact cycle they are expected.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int DW      = 32;
  localparam int NWORDS  = 4;
  localparam int IDX_W   = $clog2(NWORDS);

  // control word bit positions
  localparam int B_PEND   = 0;
  localparam int B_IEN    = 4;
  localparam int B_DRAIN  = 6;
  localparam int B_RST    = 7;
  localparam int B_DIR    = 8;
  localparam int B_EN     = 9;
  localparam int B_LOADED = 26;

  localparam logic [DW-1:0] RO_MASK = 32'hFE00_0007;
  localparam logic [DW-1:0] VERSION = 32'hA000_0000;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 2'd0,
    IDX_ADDR  = 2'd1,
    IDX_SPARE = 2'd2,
    IDX_BASE  = 2'd3
  } word_idx_e;
endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [3:0]            req_be,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic [NWORDS-1:0]     wr_en,
  output logic [IDX_W-1:0]      rd_idx,
  output logic                  req_ready
);
  localparam int IDX_LSB = 2;

  logic full_word;
  logic unused_addr_bits;

  assign unused_addr_bits = ^{req_addr[ADDR_W-1:IDX_LSB+IDX_W], req_addr[IDX_LSB-1:0]};
  assign rd_idx    = req_addr[IDX_LSB +: IDX_W];
  assign full_word = &req_be;
  assign req_ready = req_valid;

  always_comb begin
    for (int i = 0; i < NWORDS; i++) begin
      wr_en[i] = req_valid && req_write && full_word && (rd_idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          set_loaded,
  input  logic          per_irq_in,
  output logic [DW-1:0] ctrl_q,
  output logic          per_reset,
  output logic          dma_en_out,
  output logic          dir_to_mem,
  output logic          irq_out
);
  logic [DW-1:0] ctrl_d;
  logic [DW-1:0] wr_val;
  logic          irq_prev_q;
  logic          irq_rise, irq_fall;
  logic          pulse_q, pulse_d;
  logic          ctrl_ce;

  assign irq_rise = per_irq_in && !irq_prev_q;
  assign irq_fall = !per_irq_in && irq_prev_q;
  assign ctrl_ce  = wr_ctrl || set_loaded || irq_rise || irq_fall;

  // write value after the side-effect rewrite
  always_comb begin
    wr_val  = wdata;
    pulse_d = 1'b0;
    if (wdata[B_RST]) begin
      pulse_d = wr_ctrl;
    end else if (wdata[B_DRAIN]) begin
      wr_val[B_DRAIN] = 1'b0;
    end else if (wdata == '0) begin
      wr_val[B_DRAIN] = 1'b1;
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = (ctrl_q & RO_MASK) | (wr_val & ~RO_MASK) | VERSION;
    end
    if (set_loaded) begin
      ctrl_d[B_LOADED] = 1'b1;
    end
    if (irq_rise) begin
      ctrl_d[B_PEND] = 1'b1;
    end else if (irq_fall) begin
      ctrl_d[B_PEND] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= VERSION;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev_q <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      irq_prev_q <= per_irq_in;
      pulse_q    <= pulse_d;
    end
  end

  assign per_reset  = pulse_q;
  assign dma_en_out = ctrl_q[B_EN];
  assign dir_to_mem = ctrl_q[B_DIR];
  assign irq_out    = ctrl_q[B_PEND] & ctrl_q[B_IEN];
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr
  import dmach_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic             xfer_done,
  input  logic [LEN_W-1:0] xfer_len,
  output logic [DW-1:0]    addr_q
);
  logic [DW-1:0] addr_d;
  logic          addr_ce;

  assign addr_ce = wr_addr || xfer_done;

  always_comb begin
    if (wr_addr) begin
      addr_d = wdata;
    end else begin
      addr_d = addr_q + DW'(xfer_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_ce) begin
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/dmach_word.sv
module dmach_word
  import dmach_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr) begin
      q <= wdata;
    end
  end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic [DW-1:0]     req_rdata,
  input  logic              per_irq_in,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              irq_out,
  output logic              per_reset,
  output logic              dma_en_out,
  output logic              dir_to_mem,
  output logic [DW-1:0]     xfer_addr,
  output logic [DW-1:0]     xfer_base
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NWORDS-1:0] wr_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [DW-1:0]     word_q [NWORDS];
  logic [DW-1:0]     ctrl_word;
  logic [DW-1:0]     addr_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dmach_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .req_addr  (req_addr),
    .wr_en     (wr_en),
    .rd_idx    (rd_idx),
    .req_ready (req_ready)
  );

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (g == IDX_CTRL) begin : g_ctrl
      dmach_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .wr_ctrl    (wr_en[g]),
        .wdata      (req_wdata),
        .set_loaded (wr_en[IDX_ADDR]),
        .per_irq_in (per_irq_in),
        .ctrl_q     (word_q[g]),
        .per_reset  (per_reset),
        .dma_en_out (dma_en_out),
        .dir_to_mem (dir_to_mem),
        .irq_out    (irq_out)
      );
    end else if (g == IDX_ADDR) begin : g_addr
      dmach_addr #(.LEN_W(LEN_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .wr_addr   (wr_en[g]),
        .wdata     (req_wdata),
        .xfer_done (xfer_done),
        .xfer_len  (xfer_len),
        .addr_q    (word_q[g])
      );
    end else begin : g_plain
      dmach_word u_word (
        .clk   (clk),
        .rst_n (rst_int_n),
        .wr    (wr_en[g]),
        .wdata (req_wdata),
        .q     (word_q[g])
      );
    end
  end

  assign req_rdata = word_q[rd_idx];
  assign ctrl_word = word_q[IDX_CTRL];
  assign addr_word = word_q[IDX_ADDR];
  assign xfer_addr = addr_word;
  assign xfer_base = word_q[IDX_BASE];
endmodule

// File: rtl/dmach_regs_chk.sv
module dmach_regs_chk
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [3:0]        req_be,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DW-1:0]     req_wdata,
  input logic              per_irq_in,
  input logic              xfer_done,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              per_reset,
  input logic              dma_en_out,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     addr_q
);
  logic any_wr, full_wr, ctrl_wr, addr_wr, narrow_addr_wr;
  assign any_wr         = req_valid && req_write;
  assign full_wr        = any_wr && (req_be == 4'hF);
  assign ctrl_wr        = full_wr && (req_addr[3:2] == 2'd0);
  assign addr_wr        = full_wr && (req_addr[3:2] == 2'd1);
  assign narrow_addr_wr = any_wr && (req_be != 4'hF) && (req_addr[3:2] == 2'd1);

  // R7: a reset pulse is always caused by a control write with bit 7 set
  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    per_reset |-> $past(ctrl_wr && req_wdata[B_RST]));

  // R4: version field never leaves 101
  a_r4_version: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[31:29] == 3'b101);

  // R8: the enable level moves only after a control write
  a_r8_en_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dma_en_out) |-> $past(ctrl_wr));

  // R9: a rising interrupt edge sets the pending bit
  a_r9_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_irq_in) |=> ctrl_q[B_PEND]);

  // R11: address write marks the address loaded
  a_r11_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ctrl_q[B_LOADED]);

  // R12: transfer strobe without bus write advances the address
  a_r12_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !addr_wr) |=> addr_q == $past(addr_q) + DW'($past(xfer_len)));

  // R3: a partial write to the address word changes nothing
  a_r3_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_addr_wr && !xfer_done) |=> $stable(addr_q));
endmodule

bind dmach_regs dmach_regs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_be     (req_be),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .per_irq_in (per_irq_in),
  .xfer_done  (xfer_done),
  .xfer_len   (xfer_len),
  .per_reset  (per_reset),
  .dma_en_out (dma_en_out),
  .ctrl_q     (ctrl_word),
  .addr_q     (addr_word)
);

// File: tb/tb_dmach_regs.sv
module tb_dmach_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int LEN_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [3:0]        req_be;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              req_ready;
  logic [31:0]       req_rdata;
  logic              per_irq_in;
  logic              xfer_done;
  logic [LEN_W-1:0]  xfer_len;
  logic              irq_out, per_reset, dma_en_out, dir_to_mem;
  logic [31:0]       xfer_addr, xfer_base;

  int errors = 0;
  int checks = 0;

  dmach_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata), .per_irq_in(per_irq_in),
    .xfer_done(xfer_done), .xfer_len(xfer_len), .irq_out(irq_out),
    .per_reset(per_reset), .dma_en_out(dma_en_out), .dir_to_mem(dir_to_mem),
    .xfer_addr(xfer_addr), .xfer_base(xfer_base)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'h0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'hF;
    #1;
    d = req_rdata;
    req_valid = 1'b0;
    #1;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(12'h000, v); check("R1 ctrl", v, 32'hA000_0000);
    rd(12'h004, v); check("R1 addr", v, 32'h0);
    rd(12'h008, v); check("R1 spare", v, 32'h0);
    rd(12'h00C, v); check("R1 base", v, 32'h0);
    check("R1 outputs", {28'h0, irq_out, per_reset, dma_en_out, dir_to_mem}, 32'h0);
  endtask

  task automatic test_words();
    logic [31:0] v;
    wr(12'h008, 32'h1234_5678);
    wr(12'h01C, 32'hCAFE_0000);          // aliases word 3
    rd(12'h008, v); check("R2 spare", v, 32'h1234_5678);
    rd(12'hF18, v); check("R2 alias read", v, 32'h1234_5678);
    rd(12'h00C, v); check("R2 base", v, 32'hCAFE_0000);
    check("R2 base out", xfer_base, 32'hCAFE_0000);
  endtask

  task automatic test_narrow();
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h00C; req_wdata = 32'h0000_FFFF; req_be = 4'h3;
    #1; check("R3 ready same cycle", {31'h0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'h0;
    #1; check("R3 idle ready low", {31'h0, req_ready}, 32'h0);
    rd(12'h00C, v); check("R3 narrow ignored", v, 32'hCAFE_0000);
    wr(12'h004, 32'h0000_0099, 4'hE);
    rd(12'h004, v); check("R3 narrow addr ignored", v, 32'h0);
    rd(12'h000, v); check("R3 no loaded after narrow", v, 32'hA000_0000);
  endtask

  task automatic test_ro();
    logic [31:0] v;
    wr(12'h000, 32'h0000_0217);
    rd(12'h000, v); check("R4 low ro bits", v, 32'hA000_0210);
    check("R8 enable high", {31'h0, dma_en_out}, 32'h1);
    wr(12'h000, 32'h5E00_0010);
    rd(12'h000, v); check("R4 high ro bits", v, 32'hA000_0010);
    check("R8 enable low", {31'h0, dma_en_out}, 32'h0);
  endtask

  task automatic test_zero_drain();
    logic [31:0] v;
    wr(12'h000, 32'h0);
    rd(12'h000, v); check("R5 zero becomes drain", v, 32'hA000_0040);
    wr(12'h000, 32'h0000_0250);
    rd(12'h000, v); check("R6 drain self-clears", v, 32'hA000_0210);
  endtask

  task automatic test_reset_bit();
    logic [31:0] v;
    check("R7 pulse idle", {31'h0, per_reset}, 32'h0);
    wr(12'h000, 32'h0000_00C0);
    check("R7 pulse high", {31'h0, per_reset}, 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {31'h0, per_reset}, 32'h0);
    rd(12'h000, v); check("R7 stored", v, 32'hA000_00C0);
  endtask

  task automatic test_irq();
    logic [31:0] v;
    wr(12'h000, 32'h0000_0100);
    check("R8 direction", {31'h0, dir_to_mem}, 32'h1);
    wr(12'h000, 32'h0000_0101);           // bit 0 is not writable
    rd(12'h000, v); check("R9 pend not writable", v, 32'hA000_0100);
    @(negedge clk); per_irq_in = 1'b1;
    #1; rd(12'h000, v); check("R9 not yet pending", v, 32'hA000_0100);
    @(negedge clk);
    rd(12'h000, v); check("R9 pending set", v, 32'hA000_0101);
    check("R10 gated off", {31'h0, irq_out}, 32'h0);
    wr(12'h000, 32'h0000_0110);
    check("R10 gate opens", {31'h0, irq_out}, 32'h1);
    wr(12'h000, 32'h0000_0100);
    check("R10 gate closes", {31'h0, irq_out}, 32'h0);
    rd(12'h000, v); check("R9 pending kept", v, 32'hA000_0101);
    wr(12'h000, 32'h0000_0110);
    @(negedge clk); per_irq_in = 1'b0;
    @(negedge clk);
    rd(12'h000, v); check("R9 pending cleared", v, 32'hA000_0110);
    check("R10 follows pending", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic test_addr();
    logic [31:0] v;
    wr(12'h004, 32'h0000_1000);
    rd(12'h000, v); check("R11 loaded set", v, 32'hA400_0110);
    wr(12'h000, 32'h0000_0010);
    rd(12'h000, v); check("R11 loaded kept", v, 32'hA400_0010);
    @(negedge clk); xfer_done = 1'b1; xfer_len = 16'h0020;
    @(negedge clk); xfer_done = 1'b0;
    check("R12 advance", xfer_addr, 32'h0000_1020);
    @(negedge clk); xfer_done = 1'b1; xfer_len = 16'hFFFF;
    @(negedge clk); @(negedge clk); xfer_done = 1'b0;
    check("R12 two max steps", xfer_addr, 32'h0002_101E);
    wr(12'h004, 32'hFFFF_FFF0);
    @(negedge clk); xfer_done = 1'b1; xfer_len = 16'h0020;
    @(negedge clk); xfer_done = 1'b0;
    rd(12'h004, v); check("R12 wrap", v, 32'h0000_0010);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h004; req_wdata = 32'h0000_0500; req_be = 4'hF;
    xfer_done = 1'b1; xfer_len = 16'h0040;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'h0; xfer_done = 1'b0;
    check("R12 bus write wins", xfer_addr, 32'h0000_0500);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_be = 4'h0;
    req_addr = '0; req_wdata = '0; per_irq_in = 1'b0; xfer_done = 1'b0; xfer_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_words();
    test_narrow();
    test_ro();
    test_zero_drain();
    test_reset_bit();
    test_irq();
    test_addr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule